// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address. It reads two entries from a page table in memory, one entry after the other. A request carries the virtual address and the base of the top-level table. The walker accepts the request only when it is idle.

The walker first reads the top-level entry. That entry gives the frame that holds the second-level table. The walker then reads the second-level entry, which gives the data frame. The physical address is that frame joined to the untouched page offset. If either entry has its valid bit clear, the walk ends at once with a fault that names the level.

Memory is reached through a simple read port. The walker raises a one-cycle request with a word address. Memory answers later with a one-cycle data-valid strobe. Only one read is ever in flight.

Top module: `ptw_top`

## Requirements
- R1: After reset, `ready_o` is 1 and `mem_req_o`, `done_o` and `fault_o` are 0.
- R2: The first read after a request is accepted goes to `ptbr_i + vaddr[31:22]*4`. Bits [31:22] are the top-level index.
- R3: When the first entry is valid, the second read goes to `entry1[31:12]<<12 + vaddr[21:12]*4`. Bits [21:12] are the second-level index.
- R4: When both entries are valid, the result has `fault_o`=0 and `fault_level_o`=0. `paddr_o` is `{entry2[31:12], vaddr[11:0]}`.
- R5: If bit 0 (valid) of the first entry is 0, the walk ends after exactly one read. The result has `fault_o`=1, `fault_level_o`=1 and `paddr_o`=0.
- R6: If bit 0 of the second entry is 0, the walk ends after exactly two reads. The result has `fault_o`=1, `fault_level_o`=2 and `paddr_o`=0.
- R7: `done_o` is high for exactly one cycle per walk. The result outputs are valid in that cycle.
- R8: `ready_o` is low from the cycle after acceptance until the walk has finished. A request held high during a walk has no effect on its reads or its result.
- R9: `mem_req_o` is high for one cycle per read. No new read is issued until the previous read has been answered by `mem_rvalid_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 32 | Virtual address to translate |
| ptbr_i | input | 32 | Byte address of the top-level table |
| ready_o | output | 1 | Walker idle; a request is taken this cycle |
| mem_req_o | output | 1 | One-cycle read request |
| mem_addr_o | output | 32 | Byte address of the entry being read |
| mem_rvalid_i | input | 1 | Read data valid strobe |
| mem_rdata_i | input | 32 | Page-table entry returned by memory |
| done_o | output | 1 | One-cycle walk completion pulse |
| fault_o | output | 1 | Completed walk ended with an invalid entry |
| fault_level_o | output | 2 | Level that faulted (1 or 2), 0 on success |
| paddr_o | output | 32 | Translated physical address, 0 on a fault |

## Verification
The bench builds the walker with its default field widths: 10 index bits for each level and a 12-bit offset. These are the only widths at which the stated bit positions hold. The bench's memory model answers after a delay that each scenario picks, from one cycle to several. This exercises the in-flight read rule over long waits. Indices of zero and of the largest value reach the low and high ends of both address sums. A request held high through a whole walk shows whether the idle-only acceptance rule holds.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_TOP  = 3'd1,
    ST_WT_TOP  = 3'd2,
    ST_RD_LEAF = 3'd3,
    ST_WT_LEAF = 3'd4,
    ST_OK      = 3'd5,
    ST_FAULT   = 3'd6
  } walk_state_t;

  localparam logic [1:0] LVL_NONE = 2'd0;
  localparam logic [1:0] LVL_TOP  = 2'd1;
  localparam logic [1:0] LVL_LEAF = 2'd2;

endpackage

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        rvalid,
  input  logic        pte_valid,
  output walk_state_t state,
  output logic        ld_req,
  output logic        ld_next,
  output logic        ld_ok,
  output logic        ld_flt_top,
  output logic        ld_flt_leaf,
  output logic        sel_leaf,
  output logic        mem_req,
  output logic        ready,
  output logic        done,
  output logic        fault
);

  walk_state_t state_q, state_d;

  always_comb begin
    state_d     = state_q;
    ld_req      = 1'b0;
    ld_next     = 1'b0;
    ld_ok       = 1'b0;
    ld_flt_top  = 1'b0;
    ld_flt_leaf = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_req  = 1'b1;
          state_d = ST_RD_TOP;
        end
      end
      ST_RD_TOP:  state_d = ST_WT_TOP;
      ST_WT_TOP: begin
        if (rvalid) begin
          if (pte_valid) begin
            ld_next = 1'b1;
            state_d = ST_RD_LEAF;
          end else begin
            ld_flt_top = 1'b1;
            state_d    = ST_FAULT;
          end
        end
      end
      ST_RD_LEAF: state_d = ST_WT_LEAF;
      ST_WT_LEAF: begin
        if (rvalid) begin
          if (pte_valid) begin
            ld_ok   = 1'b1;
            state_d = ST_OK;
          end else begin
            ld_flt_leaf = 1'b1;
            state_d     = ST_FAULT;
          end
        end
      end
      ST_OK:    state_d = ST_IDLE;
      ST_FAULT: state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state    = state_q;
  assign sel_leaf = (state_q == ST_RD_LEAF);
  assign mem_req  = (state_q == ST_RD_TOP) || (state_q == ST_RD_LEAF);
  assign ready    = (state_q == ST_IDLE);
  assign done     = (state_q == ST_OK) || (state_q == ST_FAULT);
  assign fault    = (state_q == ST_FAULT);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_READ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R9
  AST_NO_READ_WHILE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !rvalid) |=> !mem_req); // R9
  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && req_valid) |=> (mem_req && !ready)); // R2

endmodule

// File: rtl/ptw_datapath.sv
module ptw_datapath
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned OUTER_W   = 10,
  parameter int unsigned INNER_W   = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned VALID_BIT = 0,
  localparam int unsigned VA_W     = OUTER_W + INNER_W + OFF_W,
  localparam int unsigned FRAME_W  = ADDR_W - OFF_W,
  localparam int unsigned ENT_SH   = $clog2(PTE_W / 8)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_req,
  input  logic              ld_next,
  input  logic              ld_ok,
  input  logic              ld_flt_top,
  input  logic              ld_flt_leaf,
  input  logic              sel_leaf,
  input  logic [VA_W-1:0]   vaddr,
  input  logic [ADDR_W-1:0] base,
  input  logic [PTE_W-1:0]  rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] paddr,
  output logic [1:0]        flt_lvl,
  output logic              pte_valid
);

  logic [VA_W-1:0]    va_q, va_d;
  logic [ADDR_W-1:0]  base_q, base_d;
  logic [FRAME_W-1:0] nxt_q, nxt_d;
  logic [ADDR_W-1:0]  pa_q, pa_d;
  logic [1:0]         lvl_q, lvl_d;

  logic [OUTER_W-1:0] idx_top;
  logic [INNER_W-1:0] idx_leaf;
  logic [OFF_W-1:0]   offset;
  logic [FRAME_W-1:0] pte_frame;
  logic [ADDR_W-1:0]  addr_top, addr_leaf;
  logic               res_en;

  assign idx_top   = va_q[VA_W-1 -: OUTER_W];
  assign idx_leaf  = va_q[OFF_W +: INNER_W];
  assign offset    = va_q[OFF_W-1:0];
  assign pte_frame = rdata[PTE_W-1 -: FRAME_W];
  assign pte_valid = rdata[VALID_BIT];

  assign addr_top  = base_q + (ADDR_W'(idx_top) << ENT_SH);
  assign addr_leaf = (ADDR_W'(nxt_q) << OFF_W) + (ADDR_W'(idx_leaf) << ENT_SH);
  assign mem_addr  = sel_leaf ? addr_leaf : addr_top;

  assign res_en = ld_ok | ld_flt_top | ld_flt_leaf;

  always_comb begin
    va_d   = va_q;
    base_d = base_q;
    nxt_d  = nxt_q;
    pa_d   = pa_q;
    lvl_d  = lvl_q;
    if (ld_req) begin
      va_d   = vaddr;
      base_d = base;
    end
    if (ld_next) nxt_d = pte_frame;
    if (res_en) begin
      if (ld_ok) begin
        pa_d  = {pte_frame, offset};
        lvl_d = LVL_NONE;
      end else begin
        pa_d  = '0;
        lvl_d = ld_flt_top ? LVL_TOP : LVL_LEAF;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      nxt_q  <= '0;
      pa_q   <= '0;
      lvl_q  <= LVL_NONE;
    end else begin
      if (ld_req)  va_q   <= va_d;
      if (ld_req)  base_q <= base_d;
      if (ld_next) nxt_q  <= nxt_d;
      if (res_en)  pa_q   <= pa_d;
      if (res_en)  lvl_q  <= lvl_d;
    end
  end

  assign paddr   = pa_q;
  assign flt_lvl = lvl_q;

  AST_ONE_RESULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({ld_ok, ld_flt_top, ld_flt_leaf}) <= 1); // R4
  AST_FAULT_CLEARS_PADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_flt_top || ld_flt_leaf) |=> (paddr == '0)); // R5

endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned PTE_W     = 32,
  parameter int unsigned OUTER_W   = 10,
  parameter int unsigned INNER_W   = 10,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned VALID_BIT = 0,
  localparam int unsigned VA_W     = OUTER_W + INNER_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic [VA_W-1:0]   req_vaddr_i,
  input  logic [ADDR_W-1:0] ptbr_i,
  output logic              ready_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [PTE_W-1:0]  mem_rdata_i,
  output logic              done_o,
  output logic              fault_o,
  output logic [1:0]        fault_level_o,
  output logic [ADDR_W-1:0] paddr_o
);

  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  walk_state_t state;
  logic        ld_req, ld_next, ld_ok, ld_flt_top, ld_flt_leaf, sel_leaf, pte_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ptw_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid_i),
    .rvalid      (mem_rvalid_i),
    .pte_valid   (pte_valid),
    .state       (state),
    .ld_req      (ld_req),
    .ld_next     (ld_next),
    .ld_ok       (ld_ok),
    .ld_flt_top  (ld_flt_top),
    .ld_flt_leaf (ld_flt_leaf),
    .sel_leaf    (sel_leaf),
    .mem_req     (mem_req_o),
    .ready       (ready_o),
    .done        (done_o),
    .fault       (fault_o)
  );

  ptw_datapath #(
    .ADDR_W    (ADDR_W),
    .PTE_W     (PTE_W),
    .OUTER_W   (OUTER_W),
    .INNER_W   (INNER_W),
    .OFF_W     (OFF_W),
    .VALID_BIT (VALID_BIT)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ld_req      (ld_req),
    .ld_next     (ld_next),
    .ld_ok       (ld_ok),
    .ld_flt_top  (ld_flt_top),
    .ld_flt_leaf (ld_flt_leaf),
    .sel_leaf    (sel_leaf),
    .vaddr       (req_vaddr_i),
    .base        (ptbr_i),
    .rdata       (mem_rdata_i),
    .mem_addr    (mem_addr_o),
    .paddr       (paddr_o),
    .flt_lvl     (fault_level_o),
    .pte_valid   (pte_valid)
  );

  AST_FAULT_HAS_LEVEL: assert property (@(posedge clk) disable iff (!rst_int_n)
    fault_o |-> (fault_level_o == LVL_TOP || fault_level_o == LVL_LEAF)); // R6
  AST_SUCCESS_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_int_n)
    (done_o && !fault_o) |-> (fault_level_o == LVL_NONE)); // R4
  AST_READY_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    ready_o |-> (!mem_req_o && !done_o)); // R8

endmodule

// File: tb/test_ptw_top.sv
module test_ptw_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_CYCLES = 100000;

  logic        clk;
  logic        rst_n;
  logic        req_valid_i;
  logic [31:0] req_vaddr_i;
  logic [31:0] ptbr_i;
  logic        ready_o;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        done_o;
  logic        fault_o;
  logic [1:0]  fault_level_o;
  logic [31:0] paddr_o;

  int errors = 0;
  int checks = 0;

  logic [31:0] mem [logic [31:0]];
  int          lat = 1;
  int          pend_cnt = 0;
  logic [31:0] pend_addr;
  int          nreads = 0;
  int          overlap = 0;
  logic [31:0] rd_log [0:3];

  ptw_top i_ptw_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid_i),
    .req_vaddr_i   (req_vaddr_i),
    .ptbr_i        (ptbr_i),
    .ready_o       (ready_o),
    .mem_req_o     (mem_req_o),
    .mem_addr_o    (mem_addr_o),
    .mem_rvalid_i  (mem_rvalid_i),
    .mem_rdata_i   (mem_rdata_i),
    .done_o        (done_o),
    .fault_o       (fault_o),
    .fault_level_o (fault_level_o),
    .paddr_o       (paddr_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Memory model: request seen at a negedge, answered lat negedges later.
  initial begin
    mem_rvalid_i = 1'b0;
    mem_rdata_i  = '0;
    forever begin
      @(negedge clk);
      mem_rvalid_i = 1'b0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mem_rvalid_i = 1'b1;
          mem_rdata_i  = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
        end
      end
      if (mem_req_o) begin
        if (pend_cnt > 0) overlap++;
        pend_addr = mem_addr_o;
        pend_cnt  = lat;
        if (nreads < 4) rd_log[nreads] = mem_addr_o;
        nreads++;
      end
    end
  end

  initial begin
    repeat (WDOG_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic do_reset();
    rst_n       = 1'b0;
    req_valid_i = 1'b0;
    req_vaddr_i = '0;
    ptbr_i      = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic test_reset();
    check(ready_o == 1'b1, "R1 ready after reset", 32'(ready_o), 32'd1);
    check(mem_req_o == 1'b0 && done_o == 1'b0 && fault_o == 1'b0,
          "R1 outputs idle after reset", {29'd0, mem_req_o, done_o, fault_o}, 32'd0);
  endtask

  // One walk; entries are built from the requirement fields.
  task automatic run_case(input string name, input logic [31:0] va, input logic [31:0] base,
                          input logic [19:0] f1, input bit v1, input logic [19:0] f2, input bit v2,
                          input int latency, input bit noise);
    logic [31:0] a1, a2, exp_pa;
    int exp_reads, waited, done_cnt;
    bit seen;
    a1 = base + {20'd0, va[31:22], 2'b00};
    a2 = {f1, 12'd0} + {20'd0, va[21:12], 2'b00};
    mem.delete();
    mem[a1] = {f1, 11'd0, v1};
    mem[a2] = {f2, 11'd0, v2};
    lat = latency;
    nreads = 0;
    overlap = 0;
    exp_reads = v1 ? 2 : 1;
    exp_pa = (v1 && v2) ? {f2, va[11:0]} : 32'd0;
    @(negedge clk);
    req_valid_i = 1'b1;
    req_vaddr_i = va;
    ptbr_i      = base;
    @(negedge clk);
    check(ready_o == 1'b0, {"R8 busy after accept ", name}, 32'(ready_o), 32'd0);
    if (noise) begin
      req_vaddr_i = ~va;
      ptbr_i      = base + 32'h100;
    end else begin
      req_valid_i = 1'b0;
    end
    waited = 0;
    seen = 1'b0;
    while (!seen && waited < 200) begin
      if (done_o) seen = 1'b1;
      else begin
        if (waited > 0) check(ready_o == 1'b0, {"R8 busy during walk ", name}, 32'(ready_o), 32'd0);
        @(negedge clk);
        waited++;
      end
    end
    req_valid_i = 1'b0;
    check(seen, {"R7 done reached ", name}, 32'(seen), 32'd1);
    check(nreads == exp_reads, {"R5 R6 read count ", name}, 32'(nreads), 32'(exp_reads));
    check(rd_log[0] == a1, {"R2 top-level address ", name}, rd_log[0], a1);
    if (v1) check(rd_log[1] == a2, {"R3 leaf address ", name}, rd_log[1], a2);
    check(paddr_o == exp_pa, {"R4 paddr ", name}, paddr_o, exp_pa);
    if (!v1) begin
      check(fault_o && fault_level_o == 2'd1, {"R5 fault level 1 ", name},
            {29'd0, fault_o, fault_level_o}, 32'h5);
    end else if (!v2) begin
      check(fault_o && fault_level_o == 2'd2, {"R6 fault level 2 ", name},
            {29'd0, fault_o, fault_level_o}, 32'h6);
    end else begin
      check(!fault_o && fault_level_o == 2'd0, {"R4 no fault ", name},
            {29'd0, fault_o, fault_level_o}, 32'h0);
    end
    done_cnt = 0;
    repeat (4) begin
      @(negedge clk);
      if (done_o) done_cnt++;
    end
    check(done_cnt == 0, {"R7 single-cycle done ", name}, 32'(done_cnt), 32'd0);
    check(nreads == exp_reads, {"R8 no extra reads ", name}, 32'(nreads), 32'(exp_reads));
    check(overlap == 0, {"R9 one read in flight ", name}, 32'(overlap), 32'd0);
    check(ready_o == 1'b1, {"R8 ready after walk ", name}, 32'(ready_o), 32'd1);
  endtask

  task automatic test_basic();
    run_case("basic", 32'h0040_3ABC, 32'h0001_0000, 20'h00020, 1'b1, 20'hABCDE, 1'b1, 1, 1'b0);
  endtask

  task automatic test_max_index_slow();
    run_case("max-index", 32'hFFFF_F123, 32'h0003_0000, 20'h00555, 1'b1, 20'hFEDCB, 1'b1, 5, 1'b0);
  endtask

  task automatic test_zero_index();
    run_case("zero-index", 32'h0000_0000, 32'h0000_4000, 20'h00001, 1'b1, 20'h00002, 1'b1, 2, 1'b0);
  endtask

  task automatic test_fault_top();
    run_case("fault-top", 32'h1234_5678, 32'h0001_0000, 20'h00077, 1'b0, 20'h00088, 1'b1, 3, 1'b0);
  endtask

  task automatic test_fault_leaf();
    run_case("fault-leaf", 32'h8765_4321, 32'h0002_0000, 20'h00099, 1'b1, 20'h000AA, 1'b0, 2, 1'b0);
  endtask

  task automatic test_busy_request();
    run_case("held-request", 32'h00C0_5FFF, 32'h0001_0000, 20'h00033, 1'b1, 20'h12345, 1'b1, 4, 1'b1);
  endtask

  initial begin
    do_reset();
    test_reset();
    test_basic();
    test_max_index_slow();
    test_zero_index();
    test_fault_top();
    test_basic();
    test_fault_leaf();
    test_busy_request();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule